// File: doc/BRIEF.md
# Stalling Split-Transaction MSI Cache Controller

This controller keeps MSI coherence state for a small, fixed set of blocks in a private cache on a snooping bus. The bus has two independent channels: a request channel, on which every request is globally ordered and snooped by all caches, and a response channel that carries data tagged with the identity of the cache that asked for it. The core presents loads, stores and replacements. The controller completes hits at once. A miss or a writeback issues a GetS, GetM or PutM request and then tracks the block through transient states until the transaction finishes.

Every ordered request, including the cache's own, enters a strict first-in first-out snoop queue. Suppose the block named by the head entry is logically owned but still waiting for its data, and another cache asks for it. The head then stays in place, and everything behind it waits, until the data arrives on the response channel. Data can also arrive before the cache has seen its own request in the ordered stream. In that case the block goes into a data-held state and keeps its old logical state until its own request appears.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every block is Invalid: core_ready_o is high for every address, snp_ready_o is high, and breq_valid_o, core_hit_o, core_done_o, dsend_req_o and dsend_mem_o are all low. A load to any block issues a request.
- R2: A load in S or M, a store in M and a replacement in I or S each raise core_hit_o in the cycle of the request, with no bus request. A replacement in S leaves the block Invalid.
- R3: Op encoding is load=0, store=1, replacement=2, and request encoding is GetS=0, GetM=1, PutM=2. A load in I issues GetS, a store in I or S issues GetM, and a replacement in M issues PutM. The request appears on breq_* in the same cycle the core request is accepted, with breq_addr_o equal to the core address.
- R4: While the addressed block is in a transient state, core_ready_o is low and a core request is neither issued nor completed.
- R5: When the own request is snooped before the data response, core_done_o bit b rises in the cycle the data response for block b (rsp_dst_i equal to MY_ID) is presented.
- R6: When the data response comes first, no completion occurs then. core_done_o bit b rises in the cycle the own request for block b reaches the snoop queue head.
- R7: Suppose a block is waiting for data after its own GetS or GetM has been ordered. An other-cache GetM at the queue head stalls it, and for a pending GetM an other-cache GetS does too. Entries behind the head are not processed. In the cycle the data arrives the head is serviced, and the entries behind follow one per cycle.
- R8: In M, an other-cache GetS sends data to the requester and to memory (dsend_req_o=1, dsend_mem_o=1, dsend_dst_o = requester) and leaves S. An other-cache GetM sends data to the requester only and leaves I. In S, an other-cache GetM leaves I with no data sent.
- R9: A block that holds data for a GetM that has not yet been ordered does not send data, stall or change in response to other-cache requests. It reaches M when its own GetM is snooped.
- R10: During a writeback, the own PutM sends data to memory only (dsend_mem_o=1, dsend_req_o=0) and the block completes to I. If an other-cache GetM is snooped first, data goes to that requester only, and the later own PutM completes to I with no data sent.
- R11: A data response whose rsp_dst_i differs from MY_ID has no effect.
- R12: snp_ready_o is low while the queue holds FIFO_DEPTH entries. No accepted entry is lost, and entries are serviced in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_valid_i | input | 1 | Core request valid |
| core_op_i | input | 2 | Core op: 0 load, 1 store, 2 replacement |
| core_addr_i | input | ADDR_W | Block index of the core request |
| core_ready_o | output | 1 | Addressed block is stable and can take a request |
| core_hit_o | output | 1 | Accepted request completed this cycle without the bus |
| core_done_o | output | NUM_BLK | Per block, a miss or writeback completed this cycle |
| breq_valid_o | output | 1 | Bus request issued |
| breq_type_o | output | 2 | Request type: 0 GetS, 1 GetM, 2 PutM |
| breq_addr_o | output | ADDR_W | Block index of the issued request |
| snp_valid_i | input | 1 | Ordered request from the request channel |
| snp_type_i | input | 2 | Type of the snooped request |
| snp_src_i | input | ID_W | Identity of the requesting cache |
| snp_addr_i | input | ADDR_W | Block index of the snooped request |
| snp_ready_o | output | 1 | Snoop queue can accept an entry |
| rsp_valid_i | input | 1 | Data response on the response channel |
| rsp_dst_i | input | ID_W | Identity of the cache the data is meant for |
| rsp_addr_i | input | ADDR_W | Block index of the data response |
| dsend_req_o | output | 1 | Send block data to the requesting cache |
| dsend_mem_o | output | 1 | Send block data to memory |
| dsend_dst_o | output | ID_W | Requester identity for the data sent |
| dsend_addr_o | output | ADDR_W | Block index of the data sent |

## Verification
The assertions take for granted that the environment behaves as an ordered bus. A request the controller issues shows up later, exactly once, in the snoop stream with its own identity. Data responses for this cache arrive only for blocks that are waiting for data. No snoop is presented while snp_ready_o is low. The stimulus enforces this by playing the bus itself. It replays each issued request as an own snoop, sends data only after it issues a request, never sends a data response twice, and fills the queue to exactly its depth before it waits for the stall to clear.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_REPL  = 2'd2
  } core_op_e;

  typedef enum logic [1:0] {
    BUS_GETS = 2'd0,
    BUS_GETM = 2'd1,
    BUS_PUTM = 2'd2
  } bus_req_e;

  // _A: data held, own request not yet ordered; _D: ordered, awaiting data
  typedef enum logic [3:0] {
    ST_I, ST_S, ST_M,
    ST_IS_AD, ST_IS_D, ST_IS_A,
    ST_IM_AD, ST_IM_D, ST_IM_A,
    ST_SM_AD, ST_SM_D, ST_SM_A,
    ST_MI_A, ST_SI_A, ST_II_A
  } blk_state_e;

  function automatic logic is_stable(blk_state_e s);
    return (s == ST_I) || (s == ST_S) || (s == ST_M);
  endfunction
endpackage

// File: rtl/coh_snoop_fifo.sv
module coh_snoop_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == FULL);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/coh_blk_fsm.sv
module coh_blk_fsm
  import coh_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rsp_i,
  input  logic     snp_i,
  input  logic     snp_own_i,
  input  bus_req_e snp_type_i,
  input  logic     core_i,
  input  core_op_e core_op_i,
  output logic     stable_o,
  output logic     stall_o,
  output logic     send_req_o,
  output logic     send_mem_o,
  output logic     issue_o,
  output bus_req_e issue_type_o,
  output logic     hit_o,
  output logic     done_o
);
  blk_state_e st_q, s1, s2, s3;

  assign stable_o = is_stable(st_q);

  always_comb begin
    // data response first
    s1 = st_q;
    if (rsp_i) begin
      case (st_q)
        ST_IS_AD: s1 = ST_IS_A;
        ST_IS_D:  s1 = ST_S;
        ST_IM_AD: s1 = ST_IM_A;
        ST_IM_D:  s1 = ST_M;
        ST_SM_AD: s1 = ST_SM_A;
        ST_SM_D:  s1 = ST_M;
        default: ;
      endcase
    end

    // snoop queue head
    s2         = s1;
    stall_o    = 1'b0;
    send_req_o = 1'b0;
    send_mem_o = 1'b0;
    if (snp_i && snp_own_i) begin
      case (s1)
        ST_IS_AD: if (snp_type_i == BUS_GETS) s2 = ST_IS_D;
        ST_IS_A:  if (snp_type_i == BUS_GETS) s2 = ST_S;
        ST_IM_AD: if (snp_type_i == BUS_GETM) s2 = ST_IM_D;
        ST_IM_A:  if (snp_type_i == BUS_GETM) s2 = ST_M;
        ST_SM_AD: if (snp_type_i == BUS_GETM) s2 = ST_SM_D;
        ST_SM_A:  if (snp_type_i == BUS_GETM) s2 = ST_M;
        ST_MI_A, ST_SI_A: if (snp_type_i == BUS_PUTM) begin
          send_mem_o = 1'b1;
          s2         = ST_I;
        end
        ST_II_A:  if (snp_type_i == BUS_PUTM) s2 = ST_I;
        default: ;
      endcase
    end else if (snp_i) begin
      case (s1)
        ST_S: if (snp_type_i == BUS_GETM) s2 = ST_I;
        ST_M, ST_MI_A: begin
          if (snp_type_i == BUS_GETS) begin
            send_req_o = 1'b1;
            send_mem_o = 1'b1;
            s2 = (s1 == ST_M) ? ST_S : ST_SI_A;
          end else if (snp_type_i == BUS_GETM) begin
            send_req_o = 1'b1;
            s2 = (s1 == ST_M) ? ST_I : ST_II_A;
          end
        end
        ST_IS_D: stall_o = (snp_type_i == BUS_GETM);
        ST_IM_D, ST_SM_D:
          stall_o = (snp_type_i == BUS_GETS) || (snp_type_i == BUS_GETM);
        ST_SM_AD: if (snp_type_i == BUS_GETM) s2 = ST_IM_AD;
        ST_SM_A:  if (snp_type_i == BUS_GETM) s2 = ST_IM_A;
        ST_SI_A:  if (snp_type_i == BUS_GETM) s2 = ST_II_A;
        default: ;
      endcase
    end

    // core request, only accepted while the block was stable
    s3           = s2;
    issue_o      = 1'b0;
    issue_type_o = BUS_GETS;
    hit_o        = 1'b0;
    if (core_i) begin
      case (core_op_i)
        OP_LOAD: begin
          if (s2 == ST_I) begin
            issue_o = 1'b1;
            s3      = ST_IS_AD;
          end else hit_o = 1'b1;
        end
        OP_STORE: begin
          if (s2 == ST_M) hit_o = 1'b1;
          else begin
            issue_o      = 1'b1;
            issue_type_o = BUS_GETM;
            s3 = (s2 == ST_S) ? ST_SM_AD : ST_IM_AD;
          end
        end
        OP_REPL: begin
          if (s2 == ST_M) begin
            issue_o      = 1'b1;
            issue_type_o = BUS_PUTM;
            s3           = ST_MI_A;
          end else begin
            hit_o = 1'b1;
            s3    = ST_I;
          end
        end
        default: ;
      endcase
    end

    done_o = !is_stable(st_q) && is_stable(s3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_I;
    else         st_q <= s3;
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter  int unsigned NUM_BLK    = 4,
  parameter  int unsigned ID_W       = 2,
  parameter  int unsigned MY_ID      = 1,
  parameter  int unsigned FIFO_DEPTH = 4,
  localparam int unsigned ADDR_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_valid_i,
  input  logic [1:0]        core_op_i,
  input  logic [ADDR_W-1:0] core_addr_i,
  output logic              core_ready_o,
  output logic              core_hit_o,
  output logic [NUM_BLK-1:0] core_done_o,
  output logic              breq_valid_o,
  output logic [1:0]        breq_type_o,
  output logic [ADDR_W-1:0] breq_addr_o,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_type_i,
  input  logic [ID_W-1:0]   snp_src_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_ready_o,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_dst_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  output logic              dsend_req_o,
  output logic              dsend_mem_o,
  output logic [ID_W-1:0]   dsend_dst_o,
  output logic [ADDR_W-1:0] dsend_addr_o
);
  localparam int unsigned SNP_W = 2 + ID_W + ADDR_W;
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(MY_ID);

  logic              fifo_full;
  logic              head_vld, head_pop, head_stall;
  logic [SNP_W-1:0]  head_data;
  logic [ADDR_W-1:0] head_addr;
  logic [ID_W-1:0]   head_src;
  bus_req_e          head_type;
  logic              rsp_mine;

  logic [NUM_BLK-1:0] blk_stable, stall_vec, sreq_vec, smem_vec;
  logic [NUM_BLK-1:0] issue_vec, hit_vec, done_vec;
  bus_req_e           itype_vec [NUM_BLK];

  assign snp_ready_o = !fifo_full;

  coh_snoop_fifo #(.W(SNP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (snp_valid_i && !fifo_full),
    .data_i  ({snp_type_i, snp_src_i, snp_addr_i}),
    .pop_i   (head_pop),
    .full_o  (fifo_full),
    .valid_o (head_vld),
    .data_o  (head_data)
  );

  assign head_addr  = head_data[ADDR_W-1:0];
  assign head_src   = head_data[ADDR_W +: ID_W];
  assign head_type  = bus_req_e'(head_data[SNP_W-1 -: 2]);
  assign head_stall = head_vld && stall_vec[head_addr];
  assign head_pop   = head_vld && !head_stall;
  assign rsp_mine   = rsp_valid_i && (rsp_dst_i == OWN_ID);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    coh_blk_fsm u_blk (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rsp_i        (rsp_mine && (rsp_addr_i == ADDR_W'(b))),
      .snp_i        (head_vld && (head_addr == ADDR_W'(b))),
      .snp_own_i    (head_src == OWN_ID),
      .snp_type_i   (head_type),
      .core_i       (core_valid_i && core_ready_o && (core_addr_i == ADDR_W'(b))),
      .core_op_i    (core_op_e'(core_op_i)),
      .stable_o     (blk_stable[b]),
      .stall_o      (stall_vec[b]),
      .send_req_o   (sreq_vec[b]),
      .send_mem_o   (smem_vec[b]),
      .issue_o      (issue_vec[b]),
      .issue_type_o (itype_vec[b]),
      .hit_o        (hit_vec[b]),
      .done_o       (done_vec[b])
    );
  end

  assign core_ready_o = blk_stable[core_addr_i];
  assign core_hit_o   = |hit_vec;
  assign core_done_o  = done_vec;
  assign breq_valid_o = |issue_vec;
  assign breq_type_o  = itype_vec[core_addr_i];
  assign breq_addr_o  = core_addr_i;
  assign dsend_req_o  = |sreq_vec;
  assign dsend_mem_o  = |smem_vec;
  assign dsend_dst_o  = head_src;
  assign dsend_addr_o = head_addr;
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned HEAD_W  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               core_valid_i,
  input logic               core_ready_o,
  input logic               core_hit_o,
  input logic               breq_valid_o,
  input logic [ADDR_W-1:0]  breq_addr_o,
  input logic               dsend_req_o,
  input logic               dsend_mem_o,
  input logic               head_vld,
  input logic               head_pop,
  input logic [HEAD_W-1:0]  head_data,
  input logic [NUM_BLK-1:0] blk_stable
);
  // R3
  a_r3_issue_needs_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    breq_valid_o |-> (core_valid_i && core_ready_o));

  // R2
  a_r2_hit_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_hit_o |-> !breq_valid_o);

  // R4
  a_r4_busy_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    breq_valid_o |=> !blk_stable[$past(breq_addr_o)]);

  // R7
  a_r7_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_vld && !head_pop) |=> (head_vld && $stable(head_data)));

  // R7
  a_r7_send_needs_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsend_req_o || dsend_mem_o) |-> head_pop);
endmodule

bind coh_ctrl coh_ctrl_chk #(
  .NUM_BLK(NUM_BLK),
  .ADDR_W (ADDR_W),
  .HEAD_W (SNP_W)
) u_chk (.*);

// File: tb/coh_ctrl_bench.sv
`timescale 1ns/1ps
module coh_ctrl_bench;
  localparam int NB = 4;
  localparam int IDW = 2;
  localparam int MY = 1;
  localparam int AW = 2;
  localparam logic [1:0] LD = 2'd0, STO = 2'd1, RP = 2'd2;
  localparam logic [1:0] GS = 2'd0, GM = 2'd1, PM = 2'd2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic core_valid_i = 1'b0;
  logic [1:0] core_op_i = '0;
  logic [AW-1:0] core_addr_i = '0;
  logic core_ready_o, core_hit_o;
  logic [NB-1:0] core_done_o;
  logic breq_valid_o;
  logic [1:0] breq_type_o;
  logic [AW-1:0] breq_addr_o;
  logic snp_valid_i = 1'b0;
  logic [1:0] snp_type_i = '0;
  logic [IDW-1:0] snp_src_i = '0;
  logic [AW-1:0] snp_addr_i = '0;
  logic snp_ready_o;
  logic rsp_valid_i = 1'b0;
  logic [IDW-1:0] rsp_dst_i = '0;
  logic [AW-1:0] rsp_addr_i = '0;
  logic dsend_req_o, dsend_mem_o;
  logic [IDW-1:0] dsend_dst_o;
  logic [AW-1:0] dsend_addr_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  coh_ctrl #(.NUM_BLK(NB), .ID_W(IDW), .MY_ID(MY), .FIFO_DEPTH(4)) u_coh_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .core_valid_i(core_valid_i), .core_op_i(core_op_i), .core_addr_i(core_addr_i),
    .core_ready_o(core_ready_o), .core_hit_o(core_hit_o), .core_done_o(core_done_o),
    .breq_valid_o(breq_valid_o), .breq_type_o(breq_type_o), .breq_addr_o(breq_addr_o),
    .snp_valid_i(snp_valid_i), .snp_type_i(snp_type_i), .snp_src_i(snp_src_i),
    .snp_addr_i(snp_addr_i), .snp_ready_o(snp_ready_o),
    .rsp_valid_i(rsp_valid_i), .rsp_dst_i(rsp_dst_i), .rsp_addr_i(rsp_addr_i),
    .dsend_req_o(dsend_req_o), .dsend_mem_o(dsend_mem_o),
    .dsend_dst_o(dsend_dst_o), .dsend_addr_o(dsend_addr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    core_valid_i = 1'b0;
    snp_valid_i  = 1'b0;
    rsp_valid_i  = 1'b0;
  endtask

  task automatic nxt();
    @(posedge clk_i);
    #1;
    idle();
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic do_core(input logic [1:0] op, input int a);
    core_valid_i = 1'b1;
    core_op_i    = op;
    core_addr_i  = AW'(a);
  endtask

  task automatic do_snp(input logic [1:0] t, input int src, input int a);
    snp_valid_i = 1'b1;
    snp_type_i  = t;
    snp_src_i   = IDW'(src);
    snp_addr_i  = AW'(a);
  endtask

  task automatic do_rsp(input int a, input int dst);
    rsp_valid_i = 1'b1;
    rsp_addr_i  = AW'(a);
    rsp_dst_i   = IDW'(dst);
  endtask

  task automatic miss(input logic [1:0] op, input int a, input logic [1:0] t, input string req);
    do_core(op, a);
    settle();
    chk(req, "issue valid", int'(breq_valid_o), 1);
    chk(req, "issue type", int'(breq_type_o), int'(t));
    chk(req, "issue addr", int'(breq_addr_o), a);
    chk(req, "no hit on miss", int'(core_hit_o), 0);
    nxt();
  endtask

  task automatic hit(input logic [1:0] op, input int a, input string req);
    do_core(op, a);
    settle();
    chk(req, "hit", int'(core_hit_o), 1);
    chk(req, "no issue on hit", int'(breq_valid_o), 0);
    nxt();
  endtask

  task automatic fin_own_first(input int a, input logic [1:0] t);
    do_snp(t, MY, a);
    nxt();
    settle();
    chk("R5", "no done at own snoop", int'(core_done_o), 0);
    nxt();
    do_rsp(a, MY);
    settle();
    chk("R5", "done at data", int'(core_done_o), 1 << a);
    nxt();
  endtask

  task automatic fin_data_first(input int a, input logic [1:0] t);
    do_rsp(a, MY);
    settle();
    chk("R6", "no done at early data", int'(core_done_o), 0);
    nxt();
    do_snp(t, MY, a);
    nxt();
    settle();
    chk("R6", "done at own snoop", int'(core_done_o), 1 << a);
    nxt();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    #20;
    rst_ni = 1'b1;
    nxt();

    // R1 reset state
    settle();
    chk("R1", "snp_ready", int'(snp_ready_o), 1);
    chk("R1", "breq_valid", int'(breq_valid_o), 0);
    chk("R1", "dsend", int'(dsend_req_o | dsend_mem_o), 0);
    chk("R1", "done", int'(core_done_o), 0);
    chk("R1", "hit", int'(core_hit_o), 0);
    for (int b = 0; b < NB; b++) begin
      core_addr_i = AW'(b);
      #0.1;
      chk("R1", "ready per block", int'(core_ready_o), 1);
    end
    nxt();

    // Sweep: load miss per block, alternating completion order
    for (int b = 0; b < NB; b++) begin
      miss(LD, b, GS, "R1");
      core_addr_i = AW'(b);
      settle();
      chk("R4", "ready low in transient", int'(core_ready_o), 0);
      nxt();
      do_core(STO, b);
      settle();
      chk("R4", "no issue in transient", int'(breq_valid_o), 0);
      chk("R4", "no hit in transient", int'(core_hit_o), 0);
      nxt();
      if (b % 2 == 0) fin_own_first(b, GS);
      else            fin_data_first(b, GS);
      hit(LD, b, "R2");
    end

    // R3 store in S, then R2 store hit in M
    miss(STO, 0, GM, "R3");
    fin_own_first(0, GM);
    hit(STO, 0, "R2");
    hit(LD, 0, "R2");

    // R2 replacement in S silent, then store from I
    hit(RP, 3, "R2");
    miss(STO, 3, GM, "R2");
    fin_data_first(3, GM);
    hit(RP, 2, "R2");
    hit(RP, 2, "R2");
    miss(LD, 2, GS, "R2");
    fin_own_first(2, GS);

    // R8 M with other GetS
    do_snp(GS, 2, 0);
    nxt();
    settle();
    chk("R8", "req send", int'(dsend_req_o), 1);
    chk("R8", "mem send", int'(dsend_mem_o), 1);
    chk("R8", "dst", int'(dsend_dst_o), 2);
    chk("R8", "addr", int'(dsend_addr_o), 0);
    nxt();
    hit(LD, 0, "R8");
    miss(STO, 0, GM, "R8");
    fin_own_first(0, GM);

    // R8 M with other GetM, then S with other GetM
    do_snp(GM, 3, 3);
    nxt();
    settle();
    chk("R8", "getm req send", int'(dsend_req_o), 1);
    chk("R8", "getm no mem", int'(dsend_mem_o), 0);
    chk("R8", "getm dst", int'(dsend_dst_o), 3);
    nxt();
    miss(LD, 3, GS, "R8");
    fin_data_first(3, GS);
    do_snp(GM, 2, 3);
    nxt();
    settle();
    chk("R8", "S no send", int'(dsend_req_o | dsend_mem_o), 0);
    nxt();
    miss(LD, 3, GS, "R8");
    fin_data_first(3, GS);

    // R7 stall in SM^D with an entry behind for another block
    miss(STO, 1, GM, "R7");
    do_snp(GM, MY, 1);
    nxt();
    settle();
    nxt();
    do_snp(GS, 2, 1);
    nxt();
    do_snp(GM, 3, 2);
    settle();
    chk("R7", "head stalled no send", int'(dsend_req_o | dsend_mem_o), 0);
    nxt();
    for (int k = 0; k < 3; k++) begin
      do_core(LD, 2);
      settle();
      chk("R7", "entry behind waits", int'(core_hit_o), 1);
      chk("R7", "no send while stalled", int'(dsend_req_o), 0);
      nxt();
    end
    do_rsp(1, MY);
    settle();
    chk("R7", "done at data", int'(core_done_o), 2);
    chk("R7", "head serviced req", int'(dsend_req_o), 1);
    chk("R7", "head serviced mem", int'(dsend_mem_o), 1);
    chk("R7", "head dst", int'(dsend_dst_o), 2);
    chk("R7", "head addr", int'(dsend_addr_o), 1);
    nxt();
    settle();
    chk("R7", "next entry no send", int'(dsend_req_o | dsend_mem_o), 0);
    nxt();
    miss(LD, 2, GS, "R7");
    fin_data_first(2, GS);

    // R12 fill the queue behind a stalled head
    miss(STO, 1, GM, "R12");
    do_snp(GM, MY, 1);
    nxt();
    settle();
    nxt();
    do_snp(GS, 2, 1);
    settle(); chk("R12", "ready 0", int'(snp_ready_o), 1); nxt();
    do_snp(GM, 3, 0);
    settle(); chk("R12", "ready 1", int'(snp_ready_o), 1); nxt();
    do_snp(GS, 2, 3);
    settle(); chk("R12", "ready 2", int'(snp_ready_o), 1); nxt();
    do_snp(GM, 3, 2);
    settle(); chk("R12", "ready 3", int'(snp_ready_o), 1); nxt();
    settle();
    chk("R12", "full", int'(snp_ready_o), 0);
    nxt();
    do_rsp(1, MY);
    settle();
    chk("R12", "first entry dst", int'(dsend_dst_o), 2);
    chk("R12", "first entry mem", int'(dsend_mem_o), 1);
    nxt();
    settle();
    chk("R12", "ready after pop", int'(snp_ready_o), 1);
    chk("R12", "second entry req", int'(dsend_req_o), 1);
    chk("R12", "second entry dst", int'(dsend_dst_o), 3);
    chk("R12", "second entry addr", int'(dsend_addr_o), 0);
    nxt();
    settle();
    chk("R12", "third entry no send", int'(dsend_req_o | dsend_mem_o), 0);
    nxt();
    settle();
    nxt();
    miss(LD, 2, GS, "R12");
    fin_own_first(2, GS);

    // R9 IM^A ignores others
    miss(STO, 0, GM, "R9");
    do_rsp(0, MY);
    settle();
    chk("R9", "no done early", int'(core_done_o), 0);
    nxt();
    do_snp(GM, 2, 0);
    nxt();
    do_snp(GM, MY, 0);
    settle();
    chk("R9", "other ignored no send", int'(dsend_req_o | dsend_mem_o), 0);
    chk("R9", "other ignored no done", int'(core_done_o), 0);
    nxt();
    settle();
    chk("R9", "own GetM completes", int'(core_done_o), 1);
    nxt();
    hit(STO, 0, "R9");

    // R10 writeback
    miss(RP, 0, PM, "R10");
    do_snp(PM, MY, 0);
    nxt();
    settle();
    chk("R10", "mem send", int'(dsend_mem_o), 1);
    chk("R10", "no req send", int'(dsend_req_o), 0);
    chk("R10", "addr", int'(dsend_addr_o), 0);
    chk("R10", "done", int'(core_done_o), 1);
    nxt();
    miss(LD, 0, GS, "R10");
    fin_own_first(0, GS);
    miss(STO, 0, GM, "R10");
    fin_data_first(0, GM);
    miss(RP, 0, PM, "R10");
    do_snp(GM, 3, 0);
    nxt();
    do_snp(PM, MY, 0);
    settle();
    chk("R10", "other GetM req", int'(dsend_req_o), 1);
    chk("R10", "other GetM no mem", int'(dsend_mem_o), 0);
    chk("R10", "other GetM dst", int'(dsend_dst_o), 3);
    chk("R10", "no done yet", int'(core_done_o), 0);
    nxt();
    settle();
    chk("R10", "II own PutM no send", int'(dsend_req_o | dsend_mem_o), 0);
    chk("R10", "II own PutM done", int'(core_done_o), 1);
    nxt();
    miss(LD, 0, GS, "R10");
    fin_own_first(0, GS);

    // R11 data for another cache ignored
    hit(RP, 2, "R11");
    miss(LD, 2, GS, "R11");
    do_rsp(2, 2);
    settle();
    chk("R11", "foreign data no done", int'(core_done_o), 0);
    nxt();
    do_snp(GS, MY, 2);
    nxt();
    settle();
    chk("R11", "still awaiting data", int'(core_done_o), 0);
    nxt();
    do_rsp(2, MY);
    settle();
    chk("R11", "own data done", int'(core_done_o), 4);
    nxt();
    hit(LD, 2, "R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule